// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair Acknowledge Logic

This block couples two eight-line interrupt controller channels into a single sixteen-line controller. The secondary channel feeds line 2 of the primary channel. Each channel presents its winning request to this block through three signals: a pending flag, a line number and a vector base byte. The block raises one interrupt output toward the processor.

When the processor asks for an acknowledge, the block runs a two-level acknowledge. It strobes the primary channel. If the primary winner is the cascade line, it also strobes the secondary channel. It then returns the vector byte. A missing winner at either level yields the spurious vector of that level.

The block also decodes byte accesses on a small register bus. It forwards each access to the primary or secondary channel, and it holds both trigger-mode bytes locally. Each trigger-mode byte is masked on write, so that the lines wired as edge-only can never be switched to level mode.

Top module: `cascade_pair_ctrl`

## Requirements
- R1: While `sec_pend_i` is high, `casc_o` toggles: it is high the cycle after any cycle where `sec_pend_i` was high and `casc_o` was low, and it is never high two cycles in a row. Each toggle gives the primary's line 2 an edge. When `sec_pend_i` is low, `casc_o` is low the next cycle.
- R2: `int_o` is registered. It is high in the cycle after a cycle where `prim_pend_i` was high and `inta_i` was low. It is low in the cycle after an acknowledge, or after a cycle with no primary request, and is then re-evaluated from the channel state.
- R3: An acknowledge with `prim_pend_i` low returns `(prim_base_i & 0xF8) + 7` and raises neither acknowledge strobe.
- R4: An acknowledge where the primary winner is line 2 and `sec_pend_i` is high raises both strobes in the `inta_i` cycle, with `sec_ack_line_o = sec_line_i`. It returns `(sec_base_i & 0xF8) + sec_line_i`.
- R5: An acknowledge where the primary winner is line 2 and `sec_pend_i` is low raises only `prim_ack_o`. It returns `(sec_base_i & 0xF8) + 7`.
- R6: An acknowledge with any other primary winner raises only `prim_ack_o`, with `prim_ack_line_o = prim_line_i`, in the `inta_i` cycle. It returns `(prim_base_i & 0xF8) + prim_line_i`. The low three bits of a base never reach the vector.
- R7: `vec_valid_o` is high for exactly the one cycle after each cycle with `inta_i` high. `vec_o` is valid in that cycle.
- R8: The trigger-mode bytes reset to 0 and are written by byte writes to 0x4D0 (primary, kept under mask 0xF8) and 0x4D1 (secondary, kept under mask 0xDE). They appear on `trig_prim_o` and `trig_sec_o` and read back at the same addresses in the same cycle.
- R9: Byte accesses to 0x20/0x21 strobe the primary channel and accesses to 0xA0/0xA1 strobe the secondary channel, combinationally. `reg_sel_o` is address bit 0. A read returns that channel's read data.
- R10: Accesses with `bus_byte_i` low, and accesses to unmapped addresses, raise no channel strobe, change no trigger byte and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Register bus byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_byte_i | input | 1 | Access is one byte wide |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| reg_sel_o | output | 1 | Channel register select (address bit 0) |
| reg_wdata_o | output | 8 | Write data forwarded to the channels |
| prim_wr_o | output | 1 | Primary channel write strobe |
| prim_rd_o | output | 1 | Primary channel read strobe |
| prim_rdata_i | input | 8 | Primary channel read data |
| sec_wr_o | output | 1 | Secondary channel write strobe |
| sec_rd_o | output | 1 | Secondary channel read strobe |
| sec_rdata_i | input | 8 | Secondary channel read data |
| trig_prim_o | output | 8 | Primary trigger-mode byte (1 = level) |
| trig_sec_o | output | 8 | Secondary trigger-mode byte (1 = level) |
| prim_pend_i | input | 1 | Primary has a winning request |
| prim_line_i | input | 3 | Primary winning line |
| prim_base_i | input | 8 | Primary vector base |
| sec_pend_i | input | 1 | Secondary has a winning request |
| sec_line_i | input | 3 | Secondary winning line |
| sec_base_i | input | 8 | Secondary vector base |
| casc_o | output | 1 | Cascade request into primary line 2 |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge request, one cycle |
| prim_ack_o | output | 1 | Primary acknowledge strobe |
| prim_ack_line_o | output | 3 | Line acknowledged on the primary |
| sec_ack_o | output | 1 | Secondary acknowledge strobe |
| sec_ack_line_o | output | 3 | Line acknowledged on the secondary |
| vec_valid_o | output | 1 | Vector byte valid |
| vec_o | output | 8 | Interrupt vector byte |

## Verification
Some results are combinational and appear in the same cycle as their stimulus:
- the bus read data and the channel strobes;
- the acknowledge strobes and lines.

The bench checks these 1 ns after inputs change on the falling edge, before the next rising edge. Other results are registered and are due one rising edge later:
- the trigger-mode bytes;
- the vector and its valid flag;
- `int_o` and `casc_o`.

The bench samples these 1 ns after that edge, so each check lands in the one cycle where the result is defined. The cascade toggle is checked across three consecutive edges.

// File: rtl/cascade_pair_pkg.sv
package cascade_pair_pkg;
  localparam int unsigned LINE_W = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_CHAN = 2;
  localparam logic [LINE_W-1:0] SPUR_LINE = '1;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_PRIM,
    TGT_SEC,
    TGT_TRIG
  } tgt_e;
endpackage

// File: rtl/pair_bus_decode.sv
module pair_bus_decode
  import cascade_pair_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRIM_ADDR = 16'h0020,
  parameter logic [ADDR_W-1:0] SEC_ADDR  = 16'h00A0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h04D0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  output tgt_e              tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (byte_i) begin
      if (addr_i[ADDR_W-1:1] == PRIM_ADDR[ADDR_W-1:1])      tgt_o = TGT_PRIM;
      else if (addr_i[ADDR_W-1:1] == SEC_ADDR[ADDR_W-1:1])  tgt_o = TGT_SEC;
      else if (addr_i[ADDR_W-1:1] == TRIG_ADDR[ADDR_W-1:1]) tgt_o = TGT_TRIG;
    end
  end
endmodule

// File: rtl/pair_trig_regs.sv
module pair_trig_regs
  import cascade_pair_pkg::*;
#(
  parameter logic [N_CHAN-1:0][BYTE_W-1:0] MASKS = {8'hDE, 8'hF8}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic                          sel_i,
  input  logic [BYTE_W-1:0]             wdata_i,
  output logic [N_CHAN-1:0][BYTE_W-1:0] trig_o
);
  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             trig_o[g] <= '0;
      else if (wr_i && (32'(sel_i) == 32'(g))) trig_o[g] <= wdata_i & MASKS[g];
    end
  end
endmodule

// File: rtl/pair_casc_pulse.sv
module pair_casc_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic casc_o
);
  // alternate high/low so each secondary request is seen as a fresh edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_o <= 1'b0;
    else         casc_o <= req_i & ~casc_o;
  end
endmodule

// File: rtl/pair_ack_ctrl.sv
module pair_ack_ctrl
  import cascade_pair_pkg::*;
#(
  parameter logic [LINE_W-1:0] CASC_LINE = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_i,
  input  logic              prim_pend_i,
  input  logic [LINE_W-1:0] prim_line_i,
  input  logic [BYTE_W-1:0] prim_base_i,
  input  logic              sec_pend_i,
  input  logic [LINE_W-1:0] sec_line_i,
  input  logic [BYTE_W-1:0] sec_base_i,
  output logic              prim_ack_o,
  output logic [LINE_W-1:0] prim_ack_line_o,
  output logic              sec_ack_o,
  output logic [LINE_W-1:0] sec_ack_line_o,
  output logic              int_o,
  output logic              vec_valid_o,
  output logic [BYTE_W-1:0] vec_o
);
  localparam logic [BYTE_W-1:0] BASE_MASK = ~BYTE_W'((1 << LINE_W) - 1);

  logic              to_sec;
  logic [BYTE_W-1:0] base_sel;
  logic [LINE_W-1:0] line_sel;

  assign to_sec          = prim_pend_i && (prim_line_i == CASC_LINE);
  assign prim_ack_o      = inta_i && prim_pend_i;
  assign prim_ack_line_o = prim_line_i;
  assign sec_ack_o       = inta_i && to_sec && sec_pend_i;
  assign sec_ack_line_o  = sec_line_i;

  always_comb begin
    if (!prim_pend_i) begin
      base_sel = prim_base_i;
      line_sel = SPUR_LINE;
    end else if (to_sec) begin
      base_sel = sec_base_i;
      line_sel = sec_pend_i ? sec_line_i : SPUR_LINE;
    end else begin
      base_sel = prim_base_i;
      line_sel = prim_line_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o       <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      // channel state changes at the acknowledge edge; re-evaluate next cycle
      int_o       <= prim_pend_i && !inta_i;
      vec_valid_o <= inta_i;
      if (inta_i) vec_o <= (base_sel & BASE_MASK) | BYTE_W'(line_sel);
    end
  end
endmodule

// File: rtl/cascade_pair_ctrl.sv
module cascade_pair_ctrl
  import cascade_pair_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PRIM_ADDR  = 16'h0020,
  parameter logic [ADDR_W-1:0] SEC_ADDR   = 16'h00A0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR  = 16'h04D0,
  parameter logic [7:0]        PRIM_TMASK = 8'hF8,
  parameter logic [7:0]        SEC_TMASK  = 8'hDE,
  parameter logic [2:0]        CASC_LINE  = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_byte_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              reg_sel_o,
  output logic [7:0]        reg_wdata_o,
  output logic              prim_wr_o,
  output logic              prim_rd_o,
  input  logic [7:0]        prim_rdata_i,
  output logic              sec_wr_o,
  output logic              sec_rd_o,
  input  logic [7:0]        sec_rdata_i,
  output logic [7:0]        trig_prim_o,
  output logic [7:0]        trig_sec_o,
  input  logic              prim_pend_i,
  input  logic [2:0]        prim_line_i,
  input  logic [7:0]        prim_base_i,
  input  logic              sec_pend_i,
  input  logic [2:0]        sec_line_i,
  input  logic [7:0]        sec_base_i,
  output logic              casc_o,
  output logic              int_o,
  input  logic              inta_i,
  output logic              prim_ack_o,
  output logic [2:0]        prim_ack_line_o,
  output logic              sec_ack_o,
  output logic [2:0]        sec_ack_line_o,
  output logic              vec_valid_o,
  output logic [7:0]        vec_o
);
  tgt_e                          tgt;
  logic [N_CHAN-1:0][BYTE_W-1:0] trig;

  pair_bus_decode #(
    .ADDR_W(ADDR_W), .PRIM_ADDR(PRIM_ADDR), .SEC_ADDR(SEC_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) u_dec (
    .addr_i(bus_addr_i), .byte_i(bus_byte_i), .tgt_o(tgt)
  );

  assign reg_sel_o   = bus_addr_i[0];
  assign reg_wdata_o = bus_wdata_i;
  assign prim_wr_o   = bus_wr_i && (tgt == TGT_PRIM);
  assign prim_rd_o   = bus_rd_i && (tgt == TGT_PRIM);
  assign sec_wr_o    = bus_wr_i && (tgt == TGT_SEC);
  assign sec_rd_o    = bus_rd_i && (tgt == TGT_SEC);

  pair_trig_regs #(.MASKS({SEC_TMASK, PRIM_TMASK})) u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_wr_i && (tgt == TGT_TRIG)), .sel_i(bus_addr_i[0]),
    .wdata_i(bus_wdata_i), .trig_o(trig)
  );
  assign trig_prim_o = trig[0];
  assign trig_sec_o  = trig[1];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (tgt)
        TGT_PRIM: bus_rdata_o = prim_rdata_i;
        TGT_SEC:  bus_rdata_o = sec_rdata_i;
        TGT_TRIG: bus_rdata_o = trig[bus_addr_i[0]];
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  pair_casc_pulse u_casc (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(sec_pend_i), .casc_o(casc_o)
  );

  pair_ack_ctrl #(.CASC_LINE(CASC_LINE)) u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i),
    .prim_pend_i(prim_pend_i), .prim_line_i(prim_line_i), .prim_base_i(prim_base_i),
    .sec_pend_i(sec_pend_i), .sec_line_i(sec_line_i), .sec_base_i(sec_base_i),
    .prim_ack_o(prim_ack_o), .prim_ack_line_o(prim_ack_line_o),
    .sec_ack_o(sec_ack_o), .sec_ack_line_o(sec_ack_line_o),
    .int_o(int_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );
endmodule

// File: rtl/cascade_pair_ctrl_chk.sv
module cascade_pair_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_wr_i,
  input logic       bus_byte_i,
  input logic       prim_wr_o,
  input logic       sec_wr_o,
  input logic [7:0] trig_prim_o,
  input logic [7:0] trig_sec_o,
  input logic       prim_pend_i,
  input logic [2:0] prim_line_i,
  input logic       sec_pend_i,
  input logic       casc_o,
  input logic       int_o,
  input logic       inta_i,
  input logic       prim_ack_o,
  input logic [2:0] prim_ack_line_o,
  input logic       sec_ack_o,
  input logic       vec_valid_o,
  input logic [7:0] vec_o
);
  p_casc_no_repeat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_o |=> !casc_o);
  p_casc_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pend_i && !casc_o) |=> casc_o);
  p_casc_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_pend_i |=> !casc_o);

  p_int_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_pend_i && !inta_i) |=> int_o);
  p_int_drop_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> !int_o);

  p_spurious_prim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !prim_pend_i) |=> (vec_o[2:0] == 3'd7));
  p_no_ack_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prim_pend_i |-> (!prim_ack_o && !sec_ack_o));

  p_sec_ack_cascade_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ack_o |-> (prim_ack_o && prim_ack_line_o == 3'd2));

  p_vec_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_valid_o);
  p_vec_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |=> !vec_valid_o);

  p_trig_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_prim_o[2:0] == 3'b000) && !trig_sec_o[0] && !trig_sec_o[5]);

  p_wide_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_byte_i) |-> (!prim_wr_o && !sec_wr_o));
  p_wide_wr_trig_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_byte_i) |=> ($stable(trig_prim_o) && $stable(trig_sec_o)));
endmodule

bind cascade_pair_ctrl cascade_pair_ctrl_chk chk_i (.*);

// File: tb/cascade_pair_ctrl_tb_top.sv
`timescale 1ns/1ps
module cascade_pair_ctrl_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic [15:0] bus_addr_i = '0;
  logic bus_wr_i = 0, bus_rd_i = 0, bus_byte_i = 0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o, reg_wdata_o;
  logic reg_sel_o, prim_wr_o, prim_rd_o, sec_wr_o, sec_rd_o;
  logic [7:0] prim_rdata_i = 8'h5A, sec_rdata_i = 8'hC3;
  logic [7:0] trig_prim_o, trig_sec_o;
  logic prim_pend_i = 0, sec_pend_i = 0;
  logic [2:0] prim_line_i = '0, sec_line_i = '0;
  logic [7:0] prim_base_i = 8'h0B, sec_base_i = 8'h75;
  logic casc_o, int_o, inta_i = 0, prim_ack_o, sec_ack_o, vec_valid_o;
  logic [2:0] prim_ack_line_o, sec_ack_line_o;
  logic [7:0] vec_o;

  cascade_pair_ctrl dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // {pp, pl[2:0], sp, sl[2:0], exp_vec[7:0], 6'b0, exp_pack, exp_sack}
  localparam logic [23:0] ACK_TAB [8] = '{
    {1'b1, 3'd0, 1'b0, 3'd0, 8'h08, 6'd0, 1'b1, 1'b0},  // R6
    {1'b1, 3'd5, 1'b0, 3'd0, 8'h0D, 6'd0, 1'b1, 1'b0},  // R6
    {1'b1, 3'd7, 1'b1, 3'd1, 8'h0F, 6'd0, 1'b1, 1'b0},  // R6
    {1'b0, 3'd0, 1'b0, 3'd0, 8'h0F, 6'd0, 1'b0, 1'b0},  // R3
    {1'b1, 3'd2, 1'b1, 3'd4, 8'h74, 6'd0, 1'b1, 1'b1},  // R4
    {1'b1, 3'd2, 1'b0, 3'd6, 8'h77, 6'd0, 1'b1, 1'b0},  // R5
    {1'b1, 3'd2, 1'b1, 3'd0, 8'h70, 6'd0, 1'b1, 1'b1},  // R4
    {1'b0, 3'd4, 1'b1, 3'd3, 8'h0F, 6'd0, 1'b0, 1'b0}   // R3
  };

  task automatic bus_idle();
    bus_wr_i = 0; bus_rd_i = 0; bus_byte_i = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk(int_o == 0 && vec_valid_o == 0 && casc_o == 0, "R2 reset", int_o, 0);
    chk(trig_prim_o == 0 && trig_sec_o == 0, "R8 reset", trig_prim_o, 0);
    #10 rst_ni = 1;
    @(negedge clk_i);

    // acknowledge table
    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = ACK_TAB[i];
      prim_pend_i = v[23]; prim_line_i = v[22:20];
      sec_pend_i = v[19];  sec_line_i = v[18:16];
      inta_i = 1;
      #1;
      chk(prim_ack_o == v[1], $sformatf("R6 prim_ack row %0d", i), prim_ack_o, v[1]);
      chk(sec_ack_o == v[0], $sformatf("R4 sec_ack row %0d", i), sec_ack_o, v[0]);
      if (v[1]) chk(prim_ack_line_o == v[22:20], "R6 prim_ack_line", prim_ack_line_o, v[22:20]);
      if (v[0]) chk(sec_ack_line_o == v[18:16], "R4 sec_ack_line", sec_ack_line_o, v[18:16]);
      @(posedge clk_i); #1;
      chk(vec_o == v[15:8], $sformatf("R3/R4/R5/R6 vec row %0d", i), vec_o, v[15:8]);
      chk(vec_valid_o == 1, "R7 valid", vec_valid_o, 1);
      chk(int_o == 0, "R2 after ack", int_o, 0);
      @(negedge clk_i);
      inta_i = 0; prim_pend_i = 0; sec_pend_i = 0;
      @(posedge clk_i); #1;
      chk(vec_valid_o == 0, "R7 single cycle", vec_valid_o, 0);
      @(negedge clk_i);
    end

    // interrupt output follows primary request
    prim_pend_i = 1;
    @(posedge clk_i); #1;
    chk(int_o == 1, "R2 raise", int_o, 1);
    @(negedge clk_i); prim_pend_i = 0;
    @(posedge clk_i); #1;
    chk(int_o == 0, "R2 drop", int_o, 0);

    // cascade toggle
    @(negedge clk_i); sec_pend_i = 1;
    @(posedge clk_i); #1; chk(casc_o == 1, "R1 rise", casc_o, 1);
    @(posedge clk_i); #1; chk(casc_o == 0, "R1 fall", casc_o, 0);
    @(posedge clk_i); #1; chk(casc_o == 1, "R1 rise again", casc_o, 1);
    @(negedge clk_i); sec_pend_i = 0;
    @(posedge clk_i); #1; chk(casc_o == 0, "R1 idle", casc_o, 0);

    // channel routing
    @(negedge clk_i);
    bus_byte_i = 1; bus_wr_i = 1; bus_addr_i = 16'h0021; bus_wdata_i = 8'h3C; #1;
    chk(prim_wr_o && !sec_wr_o && reg_sel_o && reg_wdata_o == 8'h3C, "R9 prim wr", prim_wr_o, 1);
    bus_addr_i = 16'h00A0; #1;
    chk(sec_wr_o && !prim_wr_o && !reg_sel_o, "R9 sec wr", sec_wr_o, 1);
    bus_wr_i = 0; bus_rd_i = 1; bus_addr_i = 16'h0020; #1;
    chk(prim_rd_o && bus_rdata_o == 8'h5A, "R9 prim rd", bus_rdata_o, 8'h5A);
    bus_addr_i = 16'h00A1; #1;
    chk(sec_rd_o && bus_rdata_o == 8'hC3, "R9 sec rd", bus_rdata_o, 8'hC3);
    bus_byte_i = 0; #1;
    chk(!sec_rd_o && bus_rdata_o == 0, "R10 wide rd", bus_rdata_o, 0);
    bus_byte_i = 1; bus_addr_i = 16'h0300; #1;
    chk(bus_rdata_o == 0 && !prim_rd_o && !sec_rd_o, "R10 unmapped rd", bus_rdata_o, 0);
    bus_idle();

    // trigger-mode registers
    @(negedge clk_i);
    bus_byte_i = 1; bus_wr_i = 1; bus_addr_i = 16'h04D0; bus_wdata_i = 8'hFF;
    @(negedge clk_i); bus_addr_i = 16'h04D1;
    @(negedge clk_i); bus_idle(); #1;
    chk(trig_prim_o == 8'hF8, "R8 prim mask", trig_prim_o, 8'hF8);
    chk(trig_sec_o == 8'hDE, "R8 sec mask", trig_sec_o, 8'hDE);
    bus_rd_i = 1; bus_byte_i = 1; bus_addr_i = 16'h04D1; #1;
    chk(bus_rdata_o == 8'hDE, "R8 readback", bus_rdata_o, 8'hDE);
    bus_idle();
    @(negedge clk_i);
    bus_wr_i = 1; bus_byte_i = 0; bus_addr_i = 16'h04D0; bus_wdata_i = 8'h00; #1;
    chk(!prim_wr_o && !sec_wr_o, "R10 wide wr strobe", prim_wr_o, 0);
    @(negedge clk_i); bus_idle(); #1;
    chk(trig_prim_o == 8'hF8, "R10 wide wr ignored", trig_prim_o, 8'hF8);
    @(negedge clk_i);
    bus_wr_i = 1; bus_byte_i = 1; bus_addr_i = 16'h04D0; bus_wdata_i = 8'h5F;
    @(negedge clk_i); bus_idle(); #1;
    chk(trig_prim_o == 8'h58, "R8 prim partial", trig_prim_o, 8'h58);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule